// File: doc/BRIEF.md
# Unaligned Load/Store Beat Splitter

This block sits between a core's load/store port and a 32-bit bus. The core may ask for a 1-, 2- or 4-byte operand at any byte address. The bus only moves whole 32-bit words that start at addresses that are multiples of 4. The splitter turns each request into one aligned bus beat, or two when the operand crosses a word boundary. For stores it places the operand bytes on the correct byte lanes and drives matching byte strobes. For loads it joins the returned bytes into one right-justified result.

Byte order is little-endian: operand byte j lives at address `addr + j`. The core side takes one request at a time. A request is accepted when `req_valid` and `req_ready` are both high on a clock edge. The outcome comes back as a single-cycle `rsp_valid` pulse. On the bus side, a beat completes on any edge where `bus_valid` and `bus_ready` are both high. Read data and the error flag are sampled on that same edge.

Top module: `acc_split_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its idle state: `req_ready` is 1, `bus_valid` is 0 and `rsp_valid` is 0.
- R2: Every bus beat address has bits [1:0] equal to 0. The first beat uses the request address with its two low bits cleared. A second beat, when issued, uses the first beat address plus 4.
- R3: Let off be address bits [1:0] and n the operand size in bytes. The size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. A request takes two bus beats when off + n > 4, and one beat otherwise.
- R4: Bit k of `bus_strb` selects byte lane k, which is `bus_wdata[8k+7:8k]`. Operand byte j goes to lane (off + j) mod 4 of beat (off + j) div 4. A beat's strobes mark exactly the lanes that carry operand bytes. This holds for loads and for stores.
- R5: For a store, each strobed lane carries its operand byte as placed by R4. Lanes that are not strobed carry 0. `bus_write` is 1 on store beats and 0 on load beats.
- R6: A successful load returns operand byte j, read from address addr + j, in `rsp_rdata[8j+7:8j]`. Result bytes at positions n and above are 0.
- R7: `rsp_valid` pulses high for exactly one cycle, in the cycle after the final beat's handshake. While `rsp_valid` is high, `bus_valid` is low. A store returns `rsp_rdata` = 0 and `rsp_err` = 0 when no error occurred.
- R8: `req_ready` is low from the accepting edge until the response cycle has passed. Requests offered in that window are ignored: they cause no beats and do not change the current operation.
- R9: A beat that completes with `bus_err` = 1 ends the sequence. No further beat is issued, and the response carries `rsp_err` = 1 and `rsp_rdata` = 0.
- R10: Once `bus_valid` is high, it stays high with `bus_addr`, `bus_strb`, `bus_wdata` and `bus_write` unchanged until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_wdata | input | 32 | Store operand, right-justified |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | A beat ended with a bus error |
| rsp_rdata | output | 32 | Load result, right-justified and zero-extended |
| bus_valid | output | 1 | Beat offered on the bus |
| bus_ready | input | 1 | Bus accepts the beat |
| bus_write | output | 1 | Beat direction |
| bus_addr | output | ADDR_W | Word-aligned beat address |
| bus_strb | output | 4 | Byte-lane strobes |
| bus_wdata | output | 32 | Store data, by lane |
| bus_rdata | input | 32 | Read data, valid at the handshake |
| bus_err | input | 1 | Beat error, valid at the handshake |

## Verification
Some internal faults show up within a single beat. A wrong beat-count decision or a stale offset register appears at once as a missing or extra second beat, or as strobes on the wrong lanes. A corrupted captured word or a bad merge shift shows in `rsp_rdata` one cycle after the last handshake. A faulty sequencer state shows as `req_ready` rising during a sequence, as a beat after an errored handshake, or as a response pulse longer than one cycle. The bench mixes long bus stalls, errors on either beat and requests offered while busy. These let each such fault reach the ports within the transaction that triggers it.

// File: rtl/acc_split_pkg.sv
// Shared constants, types and helpers for the beat splitter.
// Assumes a 32-bit bus of 8-bit lanes.
package acc_split_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int CNT_W  = OFF_W + 1;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_FIRST,
        SEQ_SECOND,
        SEQ_REPLY
    } seq_state_e;

    // Map the size code to a byte count (codes 2 and 3 both mean a full word).
    function automatic logic [CNT_W-1:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return CNT_W'(1);
            2'd1:    return CNT_W'(2);
            default: return CNT_W'(LANES);
        endcase
    endfunction
endpackage

// File: rtl/acc_lane_planner.sv
// Works out, from the byte offset and operand size, whether a second beat is
// needed, and which strobes and lane data each beat carries.
// Assumes nbytes is between 1 and LANES.
module acc_lane_planner #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [$clog2(LANES)-1:0]   off,
    input  logic [$clog2(LANES):0]     nbytes,
    input  logic [LANES*LANE_W-1:0]    wdata,
    output logic                       two_beats,
    output logic [LANES-1:0]           strb_lo,
    output logic [LANES-1:0]           strb_hi,
    output logic [LANES*LANE_W-1:0]    data_lo,
    output logic [LANES*LANE_W-1:0]    data_hi
);
    localparam int BUS_W = LANES * LANE_W;
    localparam int OFF_W = $clog2(LANES);
    localparam int CNT_W = OFF_W + 1;

    logic [LANES-1:0]     op_mask;
    logic [BUS_W-1:0]     op_data;
    logic [2*LANES-1:0]   wide_strb;
    logic [2*BUS_W-1:0]   wide_data;

    // Mark the operand bytes and zero the bytes above the operand size.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign op_mask[g] = (CNT_W'(g) < nbytes);
        assign op_data[g*LANE_W +: LANE_W] = op_mask[g] ? wdata[g*LANE_W +: LANE_W] : '0;
    end

    // Shift the operand across two words; the upper word spills into beat two.
    always_comb begin
        wide_strb = {{LANES{1'b0}}, op_mask} << off;
        wide_data = {{BUS_W{1'b0}}, op_data} << (32'(off) * LANE_W);
        strb_lo   = wide_strb[LANES-1:0];
        strb_hi   = wide_strb[2*LANES-1:LANES];
        data_lo   = wide_data[BUS_W-1:0];
        data_hi   = wide_data[2*BUS_W-1:BUS_W];
        two_beats = ({1'b0, off} + nbytes) > CNT_W'(LANES);
    end
endmodule

// File: rtl/acc_load_merger.sv
// Joins the words from the two beats, shifts the operand down to byte 0 and
// zero-extends it. Assumes word_hi is only used when the operand spills over.
module acc_load_merger #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic [$clog2(LANES)-1:0]   off,
    input  logic [$clog2(LANES):0]     nbytes,
    input  logic [LANES*LANE_W-1:0]    word_lo,
    input  logic [LANES*LANE_W-1:0]    word_hi,
    output logic [LANES*LANE_W-1:0]    result
);
    localparam int BUS_W = LANES * LANE_W;
    localparam int CNT_W = $clog2(LANES) + 1;

    logic [2*BUS_W-1:0] joined;

    // Bring operand byte 0 down to the lowest lane.
    always_comb joined = {word_hi, word_lo} >> (32'(off) * LANE_W);

    // Keep the operand bytes and clear everything above the operand size.
    for (genvar g = 0; g < LANES; g++) begin : g_res
        assign result[g*LANE_W +: LANE_W] =
            (CNT_W'(g) < nbytes) ? joined[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/acc_split_fsm.sv
// Sequencer: idle, first beat, optional second beat, one reply cycle.
// Assumes bus_rdata and bus_err are valid on the handshake edge.
module acc_split_fsm
    import acc_split_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic two_beats,
    input  logic bus_ready,
    input  logic bus_err,
    output logic idle,
    output logic bus_valid,
    output logic second,
    output logic cap_lo,
    output logic cap_hi,
    output logic rsp_valid,
    output logic rsp_err
);
    seq_state_e state, state_nx;
    logic       err_q;

    // Choose the next state from the handshake outcome.
    always_comb begin
        state_nx = state;
        case (state)
            SEQ_IDLE:   if (start) state_nx = SEQ_FIRST;
            SEQ_FIRST:  if (bus_ready) state_nx = (two_beats && !bus_err) ? SEQ_SECOND : SEQ_REPLY;
            SEQ_SECOND: if (bus_ready) state_nx = SEQ_REPLY;
            default:    state_nx = SEQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // Remember whether any beat of this sequence ended with an error.
    always_ff @(posedge clk) begin
        if (!rst_n || start)                 err_q <= 1'b0;
        else if (bus_valid && bus_ready)     err_q <= err_q | bus_err;
    end

    // Decode the state into control outputs.
    always_comb begin
        idle      = (state == SEQ_IDLE);
        bus_valid = (state == SEQ_FIRST) || (state == SEQ_SECOND);
        second    = (state == SEQ_SECOND);
        cap_lo    = (state == SEQ_FIRST)  && bus_ready;
        cap_hi    = (state == SEQ_SECOND) && bus_ready;
        rsp_valid = (state == SEQ_REPLY);
        rsp_err   = (state == SEQ_REPLY) && err_q;
    end

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && bus_err) |=> (!bus_valid && rsp_valid && rsp_err));
    assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> bus_valid);
endmodule

// File: rtl/acc_split_seq.sv
// Top: takes a load/store request, captures it, and drives one or two aligned
// bus beats through the planner and sequencer; the merger builds the load
// result. Assumes one request in flight and a bus that answers in the
// handshake cycle.
module acc_split_seq
    import acc_split_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [1:0]              req_size,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    output logic                    rsp_valid,
    output logic                    rsp_err,
    output logic [LANES*LANE_W-1:0] rsp_rdata,
    output logic                    bus_valid,
    input  logic                    bus_ready,
    output logic                    bus_write,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [LANES-1:0]        bus_strb,
    output logic [LANES*LANE_W-1:0] bus_wdata,
    input  logic [LANES*LANE_W-1:0] bus_rdata,
    input  logic                    bus_err
);
    localparam int BUS_W = LANES * LANE_W;

    logic              accept, two_beats, second, cap_lo, cap_hi, err_flag;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [CNT_W-1:0]  nbytes_q;
    logic [BUS_W-1:0]  wdata_q, lo_q, hi_q, merged;
    logic [LANES-1:0]  strb_lo, strb_hi;
    logic [BUS_W-1:0]  data_lo, data_hi;

    assign accept = req_valid && req_ready;

    // Capture the request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            write_q  <= 1'b0;
            nbytes_q <= CNT_W'(1);
            wdata_q  <= '0;
        end else if (accept) begin
            addr_q   <= req_addr;
            write_q  <= req_write;
            nbytes_q <= size_to_bytes(req_size);
            wdata_q  <= req_wdata;
        end
    end

    // Hold the read words returned by each beat.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= bus_rdata;
            if (cap_hi) hi_q <= bus_rdata;
        end
    end

    acc_lane_planner #(.LANES(LANES), .LANE_W(LANE_W)) u_plan (
        .off      (addr_q[OFF_W-1:0]),
        .nbytes   (nbytes_q),
        .wdata    (wdata_q),
        .two_beats(two_beats),
        .strb_lo  (strb_lo),
        .strb_hi  (strb_hi),
        .data_lo  (data_lo),
        .data_hi  (data_hi)
    );

    acc_load_merger #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
        .off    (addr_q[OFF_W-1:0]),
        .nbytes (nbytes_q),
        .word_lo(lo_q),
        .word_hi(hi_q),
        .result (merged)
    );

    acc_split_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .two_beats(two_beats),
        .bus_ready(bus_ready),
        .bus_err  (bus_err),
        .idle     (req_ready),
        .bus_valid(bus_valid),
        .second   (second),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .rsp_valid(rsp_valid),
        .rsp_err  (err_flag)
    );

    // Drive the current beat and the response.
    always_comb begin
        bus_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} + (second ? ADDR_W'(LANES) : '0);
        bus_write = write_q;
        bus_strb  = second ? strb_hi : strb_lo;
        bus_wdata = write_q ? (second ? data_hi : data_lo) : '0;
        rsp_err   = err_flag;
        rsp_rdata = (rsp_valid && !write_q && !err_flag) ? merged : '0;
    end

    assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[OFF_W-1:0] == '0));
    assert_second_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ready && !bus_err && !second && two_beats)
        |=> (bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(LANES)));
    assert_strb_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_strb != '0));
    assert_reply_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!bus_valid && !req_ready));
    assert_hold_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_strb)
                                       && $stable(bus_wdata) && $stable(bus_write)));
endmodule

// File: tb/tb_acc_split_seq.sv
module tb_acc_split_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        bus_valid, bus_ready, bus_write, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  bus_strb;

    always #10 clk = ~clk;

    acc_split_seq dut (.*);

    logic [7:0] mem [256];
    int n_checks = 0, n_fail = 0;
    logic        cur_write;
    logic [31:0] cur_addr, cur_wdata;
    int          cur_n;
    int          beats_seen, inj_err_beat, ready_mode;
    bit          stall_prev;
    logic [31:0] p_addr, p_wdata;
    logic [3:0]  p_strb;

    assign bus_rdata = {mem[{bus_addr[7:2], 2'd3}], mem[{bus_addr[7:2], 2'd2}],
                        mem[{bus_addr[7:2], 2'd1}], mem[{bus_addr[7:2], 2'd0}]};

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int size_bytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic int beats_for(logic [31:0] a, int n);
        return (int'(a[1:0]) + n > 4) ? 2 : 1;
    endfunction

    function automatic logic [3:0] strb_for(logic [31:0] a, int n, int beat);
        logic [3:0] s = '0;
        for (int j = 0; j < n; j++) begin
            int pos = int'(a[1:0]) + j;
            if (pos / 4 == beat) s[pos % 4] = 1'b1;
        end
        return s;
    endfunction

    function automatic logic [31:0] data_for(logic [31:0] a, int n, logic [31:0] d, int beat);
        logic [31:0] w = '0;
        for (int j = 0; j < n; j++) begin
            int pos = int'(a[1:0]) + j;
            if (pos / 4 == beat) w[(pos % 4)*8 +: 8] = d[j*8 +: 8];
        end
        return w;
    endfunction

    // Bus responder: ready pattern and error injection, driven at the falling edge.
    always @(negedge clk) begin
        bus_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
        bus_err   = (beats_seen == inj_err_beat);
    end

    // Bus monitor: checks each beat and models memory, between edges.
    always @(negedge clk) begin
        #4;
        if (rst_n) begin
            if (stall_prev)
                check(bus_valid && bus_addr == p_addr && bus_strb == p_strb && bus_wdata == p_wdata,
                      "R10 held beat", bus_addr, p_addr);
            if (bus_valid && bus_ready) begin
                check(beats_seen < beats_for(cur_addr, cur_n), "R3 extra beat", beats_seen, beats_for(cur_addr, cur_n));
                check(bus_addr == ({cur_addr[31:2], 2'b00} + 32'(4 * beats_seen)), "R2 beat address",
                      bus_addr, {cur_addr[31:2], 2'b00} + 32'(4 * beats_seen));
                check(bus_strb == strb_for(cur_addr, cur_n, beats_seen), "R4 strobes",
                      bus_strb, strb_for(cur_addr, cur_n, beats_seen));
                check(bus_write == cur_write, "R5 direction", bus_write, cur_write);
                if (cur_write) begin
                    check(bus_wdata == data_for(cur_addr, cur_n, cur_wdata, beats_seen), "R5 store lanes",
                          bus_wdata, data_for(cur_addr, cur_n, cur_wdata, beats_seen));
                    if (!bus_err)
                        for (int k = 0; k < 4; k++)
                            if (bus_strb[k]) mem[{bus_addr[7:2], 2'(k)}] = bus_wdata[k*8 +: 8];
                end
                beats_seen++;
            end
            stall_prev = bus_valid && !bus_ready;
            p_addr = bus_addr; p_strb = bus_strb; p_wdata = bus_wdata;
        end
    end

    task automatic run_txn(bit wr, logic [1:0] sz, logic [31:0] a, logic [31:0] d, int errb, int rmode);
        int          n = size_bytes(sz);
        int          nb = beats_for(a, n);
        logic [31:0] exp_rd = '0;
        bit          exp_err = (errb < nb);
        int          exp_beats = exp_err ? errb + 1 : nb;
        bit          busy_bad = 0;
        bit          got = 0;
        for (int j = 0; j < n; j++) exp_rd[j*8 +: 8] = mem[8'(a + 32'(j))];
        if (wr || exp_err) exp_rd = '0;
        @(negedge clk);
        cur_write = wr; cur_addr = a; cur_wdata = d; cur_n = n;
        beats_seen = 0; inj_err_beat = errb; ready_mode = rmode;
        req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
        #5;
        check(req_ready == 1'b1, "R8 idle ready", req_ready, 1);
        @(negedge clk);
        // R8: offer a different request while the sequence runs
        req_write = ~wr; req_addr = a ^ 32'h0000_0055; req_wdata = ~d; req_size = 2'd2;
        #5;
        for (int c = 0; c < 400; c++) begin
            if (rsp_valid) begin got = 1; break; end
            if (req_ready) busy_bad = 1;
            @(negedge clk); #5;
        end
        req_valid = 0;
        check(got, "R7 response arrives", got, 1);
        check(!busy_bad, "R8 ready low while busy", busy_bad, 0);
        check(beats_seen == exp_beats, "R3 R9 beat count", beats_seen, exp_beats);
        check(rsp_err == exp_err, "R9 error flag", rsp_err, exp_err);
        check(rsp_rdata == exp_rd, wr ? "R7 store rdata zero" : "R6 load result", rsp_rdata, exp_rd);
        @(negedge clk); #5;
        check(!rsp_valid && req_ready, "R7 R8 single pulse then ready", {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
        beats_seen = 0; inj_err_beat = 9; ready_mode = 0; stall_prev = 0;
        cur_addr = 0; cur_n = 1; cur_write = 0; cur_wdata = 0;
        repeat (3) @(negedge clk);
        #5;
        check(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        check(bus_valid == 1'b0, "R1 reset bus idle", bus_valid, 0);
        check(rsp_valid == 1'b0, "R1 reset no response", rsp_valid, 0);
        @(negedge clk); rst_n = 1;
        // directed corners
        run_txn(0, 2'd2, 32'h0000_0040, 0, 9, 0);            // aligned word load (R6)
        run_txn(1, 2'd2, 32'h0000_0043, 32'hA1B2C3D4, 9, 0); // word spanning, off 3 (R3 R4 R5)
        run_txn(0, 2'd2, 32'h0000_0043, 0, 9, 1);            // read it back under stalls (R6 R10)
        run_txn(1, 2'd1, 32'h0000_0013, 32'h0000BEEF, 9, 0); // half spanning
        run_txn(0, 2'd1, 32'h0000_0013, 0, 9, 0);
        run_txn(1, 2'd1, 32'h0000_0022, 32'hFFFF1234, 9, 0); // half at off 2, one beat, upper bytes dropped
        run_txn(0, 2'd2, 32'h0000_0020, 0, 9, 0);
        run_txn(1, 2'd3, 32'h0000_0081, 32'h01020304, 9, 0); // size code 3 as word
        run_txn(0, 2'd3, 32'h0000_0081, 0, 9, 0);
        for (int o = 0; o < 4; o++) run_txn(0, 2'd0, 32'h0000_0030 + 32'(o), 0, 9, 0);
        run_txn(0, 2'd2, 32'h0000_00FE, 0, 9, 0);            // wraps the model window
        run_txn(1, 2'd2, 32'h0000_0051, 32'h55667788, 0, 0); // R9 error on first beat
        run_txn(1, 2'd2, 32'h0000_0051, 32'h99AABBCC, 1, 1); // R9 error on second beat
        run_txn(0, 2'd2, 32'h0000_0051, 0, 9, 0);
        run_txn(0, 2'd2, 32'h0000_0062, 0, 1, 0);            // load error on second beat
        // constrained random
        for (int t = 0; t < 400; t++) begin
            logic [31:0] a = ($urandom & 32'hFFFF_FF00) | 32'($urandom % 256);
            int eb = (($urandom % 8) == 0) ? int'($urandom % 2) : 9;
            run_txn(1'($urandom % 2), 2'($urandom % 4), a, $urandom, eb, int'($urandom % 2));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule